// File: doc/BRIEF.md
# Phase Lock Detector with Hysteresis

This block decides whether a phase-locked loop has locked. It receives two pulse streams, the divided reference and the divided feedback, both synchronous to a fast local clock. In each comparison period it counts how many local clock cycles lie between a rising edge on one stream and the next rising edge on the other, in either order. It then compares that count with a programmable threshold.

A three-period hysteresis filter turns the per-period results into a lock bit. The lock bit changes only after three periods in a row fall on the side opposite to the current state. The lock bit is then combined with an external reference-valid bit and the lock bit of a second loop to form an active-high no-lock flag.

A larger threshold lets the lock bit rise sooner and tolerates more jitter on the input edges.

Top module: `phase_lock_monitor`

## Requirements
- R1: The phase error of a period is the number of clock cycles from the rising edge seen on one input to the next rising edge seen on the other input, in either order. Rising edges on both inputs in the same cycle give an error of 0.
- R2: A period whose error is greater than or equal to `lock_thr` counts as above threshold. An error equal to the threshold counts as above. Any smaller error counts as below.
- R3: While `locked` is 0, three consecutive below-threshold periods set `locked` to 1 in the cycle after the third period completes.
- R4: While `locked` is 1, three consecutive above-threshold periods clear `locked` to 0 in the cycle after the third period completes.
- R5: A period whose result agrees with the current `locked` state resets the consecutive count, so a later change needs three fresh periods.
- R6: If the second edge has not arrived by the cycle the wait counter reaches `TIMEOUT`, the period ends and counts as above threshold.
- R7: `no_lock` is 0 only when `ref_ok`, `locked` and `aux_lock` are all 1. In every other case it is 1, with no clock delay.
- R8: After reset, `locked` is 0, `no_lock` is 1, and the consecutive count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local measurement clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Divided reference pulse stream |
| fb_in | input | 1 | Divided feedback pulse stream |
| lock_thr | input | TW | Phase-error threshold in clock cycles |
| ref_ok | input | 1 | Reference-valid indication |
| aux_lock | input | 1 | Lock indication of the second loop |
| locked | output | 1 | Filtered lock status |
| no_lock | output | 1 | Combined genlock failure flag |

## Verification
A rising edge that is driven before posedge k is registered at that edge. A period therefore completes at the posedge where its closing edge is detected, or at the posedge where the wait counter equals `TIMEOUT`. Any change of `locked` is visible right after that posedge. The bench samples `locked` on the following falling edge, exactly one register stage later. `no_lock` is combinational and is sampled on a falling edge after its inputs settle.

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
  parameter int TW      = 8,
  parameter int TIMEOUT = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          fb_in,
  input  logic [TW-1:0] lock_thr,
  input  logic          ref_ok,
  input  logic          aux_lock,
  output logic          locked,
  output logic          no_lock
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam int MW = (TW > CW) ? TW : CW;

  logic          ref_q, fb_q;
  logic          meas, first_ref;
  logic [CW-1:0] cnt;
  logic [1:0]    run;
  logic          eval, above;

  wire ref_rise = ref_in & ~ref_q;
  wire fb_rise  = fb_in & ~fb_q;
  wire closing  = first_ref ? fb_rise : ref_rise;

  always_comb begin
    eval  = 1'b0;
    above = 1'b0;
    if (!meas) begin
      if (ref_rise && fb_rise) begin
        eval  = 1'b1;
        above = (lock_thr == '0);
      end
    end else if (closing) begin
      eval  = 1'b1;
      above = MW'(cnt) >= MW'(lock_thr);
    end else if (cnt == CW'(TIMEOUT)) begin
      eval  = 1'b1;
      above = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q     <= 1'b0;
      fb_q      <= 1'b0;
      meas      <= 1'b0;
      first_ref <= 1'b0;
      cnt       <= '0;
    end else begin
      ref_q <= ref_in;
      fb_q  <= fb_in;
      if (!meas) begin
        if (ref_rise ^ fb_rise) begin
          meas      <= 1'b1;
          first_ref <= ref_rise;
          cnt       <= CW'(1);
        end
      end else if (eval) begin
        meas <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (eval) begin
      if (above != locked)
        run <= '0;
      else if (run == 2'd2) begin
        locked <= ~locked;
        run    <= '0;
      end else
        run <= run + 2'd1;
    end
  end

  assign no_lock = ~(ref_ok & locked & aux_lock);
endmodule

module phase_lock_monitor_chk #(
  parameter int CW      = 8,
  parameter int TIMEOUT = 255
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_ok,
  input logic          aux_lock,
  input logic          locked,
  input logic          no_lock,
  input logic [1:0]    run,
  input logic          meas,
  input logic [CW-1:0] cnt
);
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n) run <= 2'd2);
  p_lock_after_three_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(run) == 2'd2);
  p_unlock_after_three_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(run) == 2'd2);
  p_wait_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    meas |-> cnt <= CW'(TIMEOUT));
  p_noref_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_ok || !aux_lock || !locked) |-> no_lock);
  p_reset_state_r8: assert property (@(posedge clk)
    !rst_n |=> (!locked && run == 2'd0));
endmodule

bind phase_lock_monitor phase_lock_monitor_chk #(.CW(CW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .aux_lock(aux_lock),
  .locked(locked), .no_lock(no_lock), .run(run), .meas(meas), .cnt(cnt)
);

// File: tb/phase_lock_monitor_tb.sv
module phase_lock_monitor_tb;
  localparam int TW = 8;
  localparam int TMO = 40;

  logic clk = 0, rst_n = 0, ref_in = 0, fb_in = 0, ref_ok = 0, aux_lock = 0;
  logic [TW-1:0] lock_thr = 8'd10;
  logic locked, no_lock;

  int tests = 0, fails = 0, cyc = 0;
  bit exp_lock = 0;
  int exp_run = 0;

  always #4 clk = ~clk;

  phase_lock_monitor #(.TW(TW), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .lock_thr(lock_thr),
    .ref_ok(ref_ok), .aux_lock(aux_lock), .locked(locked), .no_lock(no_lock));

  function automatic bit is_above(int err, int thr, bit tmo);
    return tmo || (err >= thr);
  endfunction

  function automatic bit exp_nolock(bit r, bit l, bit a);
    return !(r && l && a);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(bit above);
    if (above != exp_lock) exp_run = 0;
    else if (exp_run == 2) begin exp_lock = !exp_lock; exp_run = 0; end
    else exp_run++;
  endtask

  task automatic period(bit ref_first, int k, bit tmo, string req);
    @(negedge clk);
    if (ref_first) ref_in = 1; else fb_in = 1;
    if (tmo) begin
      repeat (TMO + 1) @(negedge clk);
    end else begin
      if (k == 0) begin ref_in = 1; fb_in = 1; end
      else begin
        repeat (k) @(negedge clk);
        ref_in = 1; fb_in = 1;
      end
      @(negedge clk);
    end
    model(is_above(k, int'(lock_thr), tmo));
    check(req, locked, exp_lock);
    ref_in = 0; fb_in = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic flag_check();
    ref_ok = 1'($urandom); aux_lock = 1'($urandom);
    #1;
    check("R7", no_lock, exp_nolock(ref_ok, exp_lock, aux_lock));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 locked", locked, 0);
    check("R8 no_lock", no_lock, 1);
    rst_n = 1;
    @(negedge clk);

    lock_thr = 8'd10;
    period(1, 3, 0, "R3 first below");
    period(0, 9, 0, "R3 second below");
    period(1, 0, 0, "R1 same-cycle below");
    check("R3 locked", locked, 1);
    ref_ok = 1; aux_lock = 1; #1;
    check("R7 all set", no_lock, 0);
    aux_lock = 0; #1;
    check("R7 aux clear", no_lock, 1);

    period(1, 10, 0, "R2 equal is above");
    period(0, 10, 0, "R2 equal is above");
    period(1, 2, 0, "R5 reset by below");
    check("R5 still locked", locked, 1);
    period(1, 12, 0, "R4 above 1");
    period(0, 0, 1, "R6 timeout above");
    period(1, TMO, 0, "R6 late edge at limit");
    check("R4 unlocked", locked, 0);

    lock_thr = 8'd0;
    period(1, 0, 0, "R2 zero thr same-cycle above");
    lock_thr = 8'd1;
    period(1, 0, 0, "R1 same-cycle below thr 1");
    period(0, 1, 0, "R2 one-cycle equal above");
    check("R5 run reset", locked, 0);

    for (int i = 0; i < 250; i++) begin
      lock_thr = TW'($urandom_range(0, 30));
      if ($urandom_range(0, 9) == 0) period(1'($urandom), 0, 1, "R6 random timeout");
      else period(1'($urandom), $urandom_range(0, TMO), 0, "R1 random period");
      flag_check();
    end

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    exp_lock = 0; exp_run = 0;
    check("R8 after reset", locked, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule